// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block screens every bus access against eight programmable address windows. An access presents an address, a write flag, an instruction-fetch flag and a privilege flag. One clock later the block returns a result: either a pass with the memory attributes of the governing window, or a fault flag. Instruction fetches and data accesses use the same window set. Where windows overlap, the window with the larger index governs. An address that no window covers can fall back to a built-in default map, but only for privileged accesses and only while that fallback is switched on.

Windows are set up through a small register bank of 32-bit words. Only privileged software may use it. A select register picks a window, and a base/attribute register pair programs that window. Three more base/attribute pairs reach the next three windows after the selected one, so four windows can be rewritten without touching the select register. The block raises no exceptions and does not touch any cache. It only flags faults and exports a memory type, a shareable bit and a cache policy.

Top module: `mem_guard`

## Requirements
- R1: Register word offsets are 0x00 identity, 0x04 control, 0x08 window select, 0x0C base and 0x10 attribute. The identity word always reads 0x00000800 (window count in bits [15:8]) and ignores writes. All other registers read zero after reset.
- R2: A register access with privilege clear has no effect on any register. A read of this kind returns zero. In both cases cfg_err pulses high in the cycle after the access. A privileged access leaves cfg_err low.
- R3: While control bit 0 (enable) is clear, every access passes with res_hit low and the default attributes, chosen by address bits [31:29]: 0 normal write-through; 1, 3 and 4 normal write-back; 2 device non-shared; 5 and 6 device shared; 7 strongly-ordered. Every default except strongly-ordered is non-shared unless stated.
- R4: Attribute word layout: bit 0 enable, [5:1] size code S, [10:8] permission, bit 12 execute-never, [17:16] memory type, bit 18 shareable, [21:20] cache policy. The base word holds address bits [31:5]. An enabled window covers 2^(S+1) bytes, aligned to that size. Base bits below the size are ignored. A window with S below 4 matches nothing.
- R5: When several enabled windows cover an address, the one with the highest index decides both the permission check and the attributes. res_region reports that index.
- R6: An enabled-unit access that no window covers passes with the default attributes of R3 only if it is privileged and control bit 1 (background enable) is set. Otherwise it faults with res_hit low.
- R7: The permission codes are as follows. 0 allows nothing. 1 allows privileged read/write only. 2 gives privileged read/write and unprivileged read. 3 gives full access. 4 gives read-only to both. 5 to 7 allow nothing.
- R8: An instruction fetch counts as a read. It is checked against the same windows as data accesses, and it faults in a window whose execute-never bit is set.
- R9: Exported type codes are 0 strongly-ordered, 1 device and 2 normal; a stored 3 is reported as normal. Strongly-ordered is always reported shared. The cache policy (0 none, 1 write-through, 2 write-back, stored 3 reported as 0) is reported only for normal memory and is 0 otherwise. A faulting result reports all attributes as zero.
- R10: Base/attribute pairs at offsets 0x14/0x18, 0x1C/0x20 and 0x24/0x28 read and write window (select+1), (select+2) and (select+3) modulo 8. The main pair reaches the selected window itself. Reads return the stored fields in the R4 positions.
- R11: res_valid is high exactly one cycle after each cycle with acc_valid high. Back-to-back accesses give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access to check this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Result valid |
| res_fault | output | 1 | Access is forbidden |
| res_hit | output | 1 | A programmed window governed the access |
| res_region | output | 3 | Index of the governing window |
| res_mtype | output | 2 | Memory type |
| res_shared | output | 1 | Shareable |
| res_cache | output | 2 | Cache policy |
| cfg_en | input | 1 | Register access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Register access is privileged |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after a read |
| cfg_err | output | 1 | Unprivileged register access seen |

## Verification
The bench targets overlap in both directions. A small, high-index window sits inside a larger low-index one, and a whole-space window then covers everything. A design that resolved by lowest index, or by first match, would return the wrong region and the wrong permission. Size edges are probed just inside and just outside each window, along with a size code below the minimum and base bits below the alignment. A faulty mask would leak accesses past a window or swallow a tiny window.

The other targets are the fallback rules, the permission codes and the register bank. Privilege and the background-enable bit are varied on uncovered addresses, and every permission code is tried with read, write and fetch. Execute-never is set on a window whose permission would otherwise allow the fetch. Alias pairs are written relative to non-zero selects, so that wraparound is exercised. Unprivileged register writes are shown to leave the control word intact.

// File: rtl/mg_pkg.sv
package mg_pkg;

    localparam int ADDR_W   = 32;
    localparam int GRAN_LOG = 5;
    localparam int BASE_W   = ADDR_W - GRAN_LOG;
    localparam int SZ_W     = 5;
    localparam int MIN_SZL  = GRAN_LOG - 1;

    typedef enum logic [1:0] {
        MT_STRONG = 2'd0,
        MT_DEVICE = 2'd1,
        MT_NORMAL = 2'd2,
        MT_RSVD   = 2'd3
    } mtype_e;

    typedef enum logic [1:0] {
        CP_NONE  = 2'd0,
        CP_WTHRU = 2'd1,
        CP_WBACK = 2'd2,
        CP_RSVD  = 2'd3
    } cpol_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
        logic [SZ_W-1:0]   szl;
        logic [2:0]        perm;
        logic              xn;
        mtype_e            mtype;
        logic              shr;
        cpol_e             cpol;
    } region_cfg_t;

    typedef struct packed {
        logic [2:0] perm;
        logic       xn;
        mtype_e     mtype;
        logic       shr;
        cpol_e      cpol;
    } rule_t;

    typedef struct packed {
        mtype_e mtype;
        logic   shr;
        cpol_e  cpol;
    } attr_t;

    function automatic attr_t default_attr(input logic [2:0] slice);
        attr_t a;
        case (slice)
            3'd0:    a = '{mtype: MT_NORMAL, shr: 1'b0, cpol: CP_WTHRU};
            3'd1,
            3'd3,
            3'd4:    a = '{mtype: MT_NORMAL, shr: 1'b0, cpol: CP_WBACK};
            3'd2:    a = '{mtype: MT_DEVICE, shr: 1'b0, cpol: CP_NONE};
            3'd5,
            3'd6:    a = '{mtype: MT_DEVICE, shr: 1'b1, cpol: CP_NONE};
            default: a = '{mtype: MT_STRONG, shr: 1'b1, cpol: CP_NONE};
        endcase
        return a;
    endfunction

    function automatic logic perm_ok(input logic [2:0] perm, input logic priv,
                                     input logic wr);
        logic ok;
        case (perm)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd4:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic attr_t export_attr(input rule_t r);
        attr_t a;
        a.mtype = (r.mtype == MT_RSVD) ? MT_NORMAL : r.mtype;
        a.shr   = (a.mtype == MT_STRONG) ? 1'b1 : r.shr;
        if (a.mtype == MT_NORMAL && r.cpol != CP_RSVD) a.cpol = r.cpol;
        else                                           a.cpol = CP_NONE;
        return a;
    endfunction

endpackage

// File: rtl/mg_region_hit.sv
module mg_region_hit
    import mg_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic              en,
    input  logic [SZ_W-1:0]   szl,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W:0]   span;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_addr;

    // Window size is 2^(szl+1); keep the address bits above it.
    always_comb begin
        span      = {(ADDR_W+1){1'b1}} << (int'(szl) + 1);
        mask      = span[ADDR_W-1:0];
        base_addr = {base, {GRAN_LOG{1'b0}}};
        hit       = en && (int'(szl) >= MIN_SZL) &&
                    ((addr & mask) == (base_addr & mask));
    end

endmodule

// File: rtl/mg_regs.sv
module mg_regs
    import mg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NALIAS = 3,
    parameter int AOFF_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_en,
    input  logic                         cfg_write,
    input  logic                         cfg_priv,
    input  logic [AOFF_W-1:0]            cfg_addr,
    input  logic [31:0]                  cfg_wdata,
    output logic [31:0]                  cfg_rdata,
    output logic                         cfg_err,
    output logic                         ctrl_on,
    output logic                         ctrl_bg,
    output region_cfg_t [NREG-1:0]       rcfg
);
    localparam int SELW    = $clog2(NREG);
    localparam int WORD_W  = AOFF_W - 2;
    localparam int W_ID    = 0;
    localparam int W_CTRL  = 1;
    localparam int W_SEL   = 2;
    localparam int W_PAIR0 = 3;
    localparam int NPAIR   = NALIAS + 1;
    localparam logic [31:0] ID_VAL = 32'(NREG) << 8;

    typedef struct packed {
        logic                   ctrl_on;
        logic                   ctrl_bg;
        logic [SELW-1:0]        sel;
        region_cfg_t [NREG-1:0] rcfg;
        logic [31:0]            rdata;
        logic                   err;
    } state_t;

    state_t q, d;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] slot;
    logic              aligned;
    logic              pair_hit;
    logic              is_attr;
    logic [SELW-1:0]   tgt;
    logic [31:0]       rd_val;
    region_cfg_t       tc;

    always_comb begin
        word     = cfg_addr[AOFF_W-1:2];
        aligned  = (cfg_addr[1:0] == 2'b00);
        slot     = '0;
        pair_hit = 1'b0;
        is_attr  = 1'b0;
        tgt      = q.sel;
        if (int'(word) >= W_PAIR0 && int'(word) < W_PAIR0 + 2*NPAIR) begin
            pair_hit = aligned;
            slot     = word - WORD_W'(W_PAIR0);
            is_attr  = slot[0];
            tgt      = q.sel + SELW'(slot >> 1);
        end
        tc = q.rcfg[tgt];

        rd_val = '0;
        if (aligned) begin
            if (int'(word) == W_ID)        rd_val = ID_VAL;
            else if (int'(word) == W_CTRL) rd_val = {30'd0, q.ctrl_bg, q.ctrl_on};
            else if (int'(word) == W_SEL)  rd_val = 32'(q.sel);
        end
        if (pair_hit) begin
            if (is_attr)
                rd_val = {10'd0, tc.cpol, 1'b0, tc.shr, tc.mtype, 3'd0, tc.xn,
                          1'b0, tc.perm, 2'd0, tc.szl, tc.en};
            else
                rd_val = {tc.base, {GRAN_LOG{1'b0}}};
        end

        d     = q;
        d.err = 1'b0;
        if (cfg_en) begin
            if (!cfg_priv) begin
                d.err = 1'b1;
                if (!cfg_write) d.rdata = '0;
            end else if (!cfg_write) begin
                d.rdata = rd_val;
            end else if (aligned && int'(word) == W_CTRL) begin
                d.ctrl_on = cfg_wdata[0];
                d.ctrl_bg = cfg_wdata[1];
            end else if (aligned && int'(word) == W_SEL) begin
                d.sel = cfg_wdata[SELW-1:0];
            end else if (pair_hit) begin
                if (is_attr) begin
                    d.rcfg[tgt].en    = cfg_wdata[0];
                    d.rcfg[tgt].szl   = cfg_wdata[5:1];
                    d.rcfg[tgt].perm  = cfg_wdata[10:8];
                    d.rcfg[tgt].xn    = cfg_wdata[12];
                    d.rcfg[tgt].mtype = mtype_e'(cfg_wdata[17:16]);
                    d.rcfg[tgt].shr   = cfg_wdata[18];
                    d.rcfg[tgt].cpol  = cpol_e'(cfg_wdata[21:20]);
                end else begin
                    d.rcfg[tgt].base  = cfg_wdata[31:GRAN_LOG];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_rdata = q.rdata;
    assign cfg_err   = q.err;
    assign ctrl_on   = q.ctrl_on;
    assign ctrl_bg   = q.ctrl_bg;
    assign rcfg      = q.rcfg;

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_en && !cfg_priv)); // R2

    AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_en && !cfg_priv) |-> (ctrl_on == $past(ctrl_on)) &&
                                       (ctrl_bg == $past(ctrl_bg))); // R2

endmodule

// File: rtl/mg_check.sv
module mg_check
    import mg_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic [2:0]             acc_slice,
    input  logic                   acc_write,
    input  logic                   acc_fetch,
    input  logic                   acc_priv,
    input  logic                   ctrl_on,
    input  logic                   ctrl_bg,
    input  logic [NREG-1:0]        hit_vec,
    input  rule_t [NREG-1:0]       rules,
    output logic                   res_valid,
    output logic                   res_fault,
    output logic                   res_hit,
    output logic [$clog2(NREG)-1:0] res_region,
    output attr_t                  res_attr
);
    localparam int SELW = $clog2(NREG);

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic            hit;
        logic [SELW-1:0] region;
        attr_t           attr;
    } res_t;

    res_t q, d;

    logic            found;
    logic [SELW-1:0] idx;
    logic            eff_wr;
    logic            bad;
    rule_t           win;
    attr_t           pick;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = SELW'(i);
            end
        end
        win    = rules[idx];
        eff_wr = acc_write && !acc_fetch;
        bad    = 1'b0;
        pick   = default_attr(acc_slice);
        if (ctrl_on) begin
            if (found) begin
                bad  = !perm_ok(win.perm, acc_priv, eff_wr) || (acc_fetch && win.xn);
                pick = export_attr(win);
            end else begin
                bad  = !(ctrl_bg && acc_priv);
            end
        end

        d       = q;
        d.valid = acc_valid;
        if (acc_valid) begin
            d.fault  = bad;
            d.hit    = ctrl_on && found;
            d.region = (ctrl_on && found) ? idx : '0;
            d.attr   = bad ? '0 : pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid  = q.valid;
    assign res_fault  = q.fault;
    assign res_hit    = q.hit;
    assign res_region = q.region;
    assign res_attr   = q.attr;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(acc_valid)); // R11

    AST_FAULT_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_attr == '0)); // R9

    AST_STRONG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault && res_attr.mtype == MT_STRONG) |-> res_attr.shr); // R9

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !ctrl_on) |-> (!res_fault && !res_hit)); // R3

    AST_UNPRIV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && $past(!acc_priv && ctrl_on)) |-> res_fault); // R6

endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NALIAS = 3,
    parameter int AOFF_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [31:0]              acc_addr,
    input  logic                     acc_write,
    input  logic                     acc_fetch,
    input  logic                     acc_priv,
    output logic                     res_valid,
    output logic                     res_fault,
    output logic                     res_hit,
    output logic [$clog2(NREG)-1:0]  res_region,
    output logic [1:0]               res_mtype,
    output logic                     res_shared,
    output logic [1:0]               res_cache,
    input  logic                     cfg_en,
    input  logic                     cfg_write,
    input  logic                     cfg_priv,
    input  logic [AOFF_W-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output logic                     cfg_err
);
    region_cfg_t [NREG-1:0] rcfg;
    rule_t       [NREG-1:0] rules;
    logic        [NREG-1:0] hit_vec;
    logic                   ctrl_on;
    logic                   ctrl_bg;
    attr_t                  res_attr;

    mg_regs #(.NREG(NREG), .NALIAS(NALIAS), .AOFF_W(AOFF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_write (cfg_write),
        .cfg_priv  (cfg_priv),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .ctrl_on   (ctrl_on),
        .ctrl_bg   (ctrl_bg),
        .rcfg      (rcfg)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_region
        mg_region_hit u_hit (
            .base (rcfg[g].base),
            .en   (rcfg[g].en),
            .szl  (rcfg[g].szl),
            .addr (acc_addr),
            .hit  (hit_vec[g])
        );
        assign rules[g] = '{perm:  rcfg[g].perm,  xn:   rcfg[g].xn,
                            mtype: rcfg[g].mtype, shr:  rcfg[g].shr,
                            cpol:  rcfg[g].cpol};
    end

    mg_check #(.NREG(NREG)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_slice  (acc_addr[31:29]),
        .acc_write  (acc_write),
        .acc_fetch  (acc_fetch),
        .acc_priv   (acc_priv),
        .ctrl_on    (ctrl_on),
        .ctrl_bg    (ctrl_bg),
        .hit_vec    (hit_vec),
        .rules      (rules),
        .res_valid  (res_valid),
        .res_fault  (res_fault),
        .res_hit    (res_hit),
        .res_region (res_region),
        .res_attr   (res_attr)
    );

    assign res_mtype  = res_attr.mtype;
    assign res_shared = res_attr.shr;
    assign res_cache  = res_attr.cpol;

endmodule

// File: tb/test_mem_guard.sv
`timescale 1ns/1ps
module test_mem_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_priv = 1'b0;
    logic        res_valid, res_fault, res_hit, res_shared;
    logic [2:0]  res_region;
    logic [1:0]  res_mtype, res_cache;
    logic        cfg_en = 1'b0;
    logic        cfg_write = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    mem_guard i_mem_guard (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .res_valid(res_valid), .res_fault(res_fault), .res_hit(res_hit),
        .res_region(res_region), .res_mtype(res_mtype), .res_shared(res_shared),
        .res_cache(res_cache),
        .cfg_en(cfg_en), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: results arrive one cycle after each access.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            logic [9:0] act;
            act = {res_fault, res_hit, res_region, res_mtype, res_shared, res_cache};
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected result", 32'(act), 32'h0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, 32'(act), 32'(e));
            end
        end
    end

    // Driver: one access per cycle; expected {fault,hit,region,mtype,shr,cache}.
    task automatic acc(input logic [31:0] a, input logic w, input logic f,
                       input logic p, input logic ef, input logic eh,
                       input logic [2:0] er, input logic [1:0] em,
                       input logic es, input logic [1:0] ec, input string tag);
        exp_q.push_back({ef, eh, er, em, es, ec});
        tag_q.push_back(tag);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0; acc_priv = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] dat, input logic p,
                      input logic exp_err, input string tag);
        cfg_en = 1'b1; cfg_write = 1'b1; cfg_priv = p; cfg_addr = a; cfg_wdata = dat;
        @(negedge clk);
        cfg_en = 1'b0; cfg_write = 1'b0; cfg_priv = 1'b0;
        check(cfg_err == exp_err, tag, 32'(cfg_err), 32'(exp_err));
    endtask

    task automatic rd(input logic [5:0] a, input logic p, input logic [31:0] exp,
                      input logic exp_err, input string tag);
        cfg_en = 1'b1; cfg_write = 1'b0; cfg_priv = p; cfg_addr = a;
        @(negedge clk);
        cfg_en = 1'b0; cfg_priv = 1'b0;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
        check(cfg_err == exp_err, {tag, " err"}, 32'(cfg_err), 32'(exp_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(res_valid == 1'b0, "R11 no result after reset", 32'(res_valid), 0);
        rd(6'h00, 1'b1, 32'h0000_0800, 1'b0, "R1 identity");
        rd(6'h04, 1'b1, 32'h0, 1'b0, "R1 control reset");
        rd(6'h08, 1'b1, 32'h0, 1'b0, "R1 select reset");
        rd(6'h0C, 1'b1, 32'h0, 1'b0, "R1 base reset");
        rd(6'h10, 1'b1, 32'h0, 1'b0, "R1 attr reset");

        // R3 unit disabled: default map by address slice
        acc(32'h2000_0100, 1, 0, 0, 0, 0, 0, 2'd2, 0, 2'd2, "R3 slice1 normal WB");
        acc(32'hE000_0000, 0, 0, 0, 0, 0, 0, 2'd0, 1, 2'd0, "R3 slice7 strongly-ordered");
        acc(32'h4000_0000, 1, 0, 0, 0, 0, 0, 2'd1, 0, 2'd0, "R3 slice2 device");
        acc(32'hA000_0000, 0, 0, 0, 0, 0, 0, 2'd1, 1, 2'd0, "R3 slice5 device shared");
        acc(32'h0000_0040, 0, 1, 0, 0, 0, 0, 2'd2, 0, 2'd1, "R3 slice0 normal WT");
        drain();

        // Window 0: 64 KiB at 0x2000_0000, full access, normal WB
        wr(6'h08, 32'd0, 1, 0, "R10 select 0");
        wr(6'h0C, 32'h2000_0000, 1, 0, "R4 base w0");
        wr(6'h10, 32'h0022_031F, 1, 0, "R4 attr w0");
        rd(6'h10, 1'b1, 32'h0022_031F, 1'b0, "R4 attr readback");
        wr(6'h04, 32'd3, 1, 0, "R6 enable with background");
        acc(32'h2000_1234, 1, 0, 0, 0, 1, 0, 2'd2, 0, 2'd2, "R4 inside w0");
        acc(32'h2000_FFFC, 0, 0, 0, 0, 1, 0, 2'd2, 0, 2'd2, "R4 top of w0");
        acc(32'h2001_0000, 0, 0, 0, 1, 0, 0, 2'd0, 0, 2'd0, "R6 unpriv miss faults");
        acc(32'h2001_0000, 0, 0, 1, 0, 0, 0, 2'd2, 0, 2'd2, "R6 priv miss background");
        drain();

        // Window 1 through alias 1 (select 0 -> window 1)
        wr(6'h14, 32'h2000_01E0, 1, 0, "R10 alias1 base");
        wr(6'h18, 32'h0005_120F, 1, 0, "R10 alias1 attr");
        rd(6'h18, 1'b1, 32'h0005_120F, 1'b0, "R10 alias1 attr read");
        wr(6'h08, 32'd1, 1, 0, "R10 select 1");
        rd(6'h0C, 1'b1, 32'h2000_01E0, 1'b0, "R10 main base of w1");
        rd(6'h10, 1'b1, 32'h0005_120F, 1'b0, "R10 main attr of w1");
        acc(32'h2000_0180, 0, 0, 0, 0, 1, 1, 2'd1, 1, 2'd0, "R5 w1 over w0");
        acc(32'h2000_01FC, 1, 0, 0, 1, 1, 1, 2'd0, 0, 2'd0, "R7 perm2 user write");
        acc(32'h2000_0180, 1, 0, 1, 0, 1, 1, 2'd1, 1, 2'd0, "R7 perm2 priv write");
        acc(32'h2000_0180, 0, 1, 1, 1, 1, 1, 2'd0, 0, 2'd0, "R8 execute-never");
        acc(32'h2000_0200, 0, 1, 0, 0, 1, 0, 2'd2, 0, 2'd2, "R8 fetch in w0");
        acc(32'h2000_00FC, 0, 0, 0, 0, 1, 0, 2'd2, 0, 2'd2, "R4 below w1 alignment");
        drain();

        // Window 7 through alias 2 with select 5
        wr(6'h08, 32'd5, 1, 0, "R10 select 5");
        wr(6'h1C, 32'h2000_0000, 1, 0, "R10 alias2 base");
        wr(6'h20, 32'h0020_0009, 1, 0, "R10 alias2 attr");
        acc(32'h2000_0010, 0, 0, 1, 1, 1, 7, 2'd0, 0, 2'd0, "R7 perm0 priv read");
        acc(32'h2000_0020, 0, 0, 1, 0, 1, 0, 2'd2, 0, 2'd2, "R4 past 32-byte w7");
        drain();
        wr(6'h20, 32'h0020_0409, 1, 0, "R10 alias2 attr RO");
        acc(32'h2000_0004, 0, 0, 0, 0, 1, 7, 2'd0, 1, 2'd0, "R9 strongly-ordered shared");
        acc(32'h2000_0004, 1, 0, 1, 1, 1, 7, 2'd0, 0, 2'd0, "R7 perm4 priv write");
        drain();

        // Window 6 through alias 3 with select 3
        wr(6'h08, 32'd3, 1, 0, "R10 select 3");
        wr(6'h24, 32'h3000_0000, 1, 0, "R10 alias3 base");
        wr(6'h28, 32'h0000_0307, 1, 0, "R4 size code 3");
        acc(32'h3000_0000, 0, 0, 1, 0, 0, 0, 2'd2, 0, 2'd2, "R4 tiny size no match");
        drain();
        wr(6'h28, 32'h0033_033F, 1, 0, "R4 whole space");
        acc(32'hF000_0000, 1, 0, 0, 0, 1, 6, 2'd2, 0, 2'd0, "R9 type3 cache3 remap");
        acc(32'h2000_0180, 1, 0, 0, 0, 1, 6, 2'd2, 0, 2'd0, "R5 w6 over w1");
        acc(32'h2000_0004, 1, 0, 0, 1, 1, 7, 2'd0, 0, 2'd0, "R5 w7 over w6");
        drain();
        wr(6'h28, 32'h0033_013F, 1, 0, "R7 perm1");
        acc(32'h5000_0000, 0, 0, 0, 1, 1, 6, 2'd0, 0, 2'd0, "R7 perm1 user read");
        acc(32'h5000_0000, 1, 0, 1, 0, 1, 6, 2'd2, 0, 2'd0, "R7 perm1 priv write");
        drain();
        wr(6'h28, 32'h0, 1, 0, "R4 disable w6");
        wr(6'h04, 32'd1, 1, 0, "R6 background off");
        acc(32'h5000_0000, 0, 0, 1, 1, 0, 0, 2'd0, 0, 2'd0, "R6 priv miss no background");
        drain();

        // R2 unprivileged register access
        wr(6'h04, 32'd0, 0, 1, "R2 unpriv write err");
        rd(6'h04, 1'b1, 32'd1, 1'b0, "R2 control kept");
        rd(6'h00, 1'b0, 32'h0, 1'b1, "R2 unpriv read zero");
        wr(6'h00, 32'h0, 1, 0, "R1 identity write");
        rd(6'h00, 1'b1, 32'h0000_0800, 1'b0, "R1 identity unchanged");
        acc(32'h2000_0004, 1, 0, 0, 1, 1, 7, 2'd0, 0, 2'd0, "R2 windows still active");
        drain();

        // R3 disabled again
        wr(6'h04, 32'd0, 1, 0, "R3 disable unit");
        acc(32'h2000_0004, 1, 0, 0, 0, 0, 0, 2'd2, 0, 2'd2, "R3 disabled passes");
        drain();
        @(negedge clk);
        check(res_valid == 1'b0, "R11 idle no result", 32'(res_valid), 0);
        check(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule